// File: doc/BRIEF.md
# Video Frame Alignment Pulse Generator

This block produces a one-clock top-of-frame (TOF) pulse from a pair of free-running counters, one for pixels and one for output lines. It runs on the pixel clock. Software programs the output format and can then ask for a one-time alignment to an incoming reference frame. The reference arrives as horizontal and vertical sync pulses that are already synchronous to the clock. The reference line on which both pulses occur together serves as the anchor. The output start of frame is placed a programmable number of reference lines after that anchor, wrapping at the reference frame length.

Alignment is armed by a rising edge on the init bit while the enable bit is set. While the enable bit stays high, the counters are reloaded on the target line of every reference frame. Clearing the enable bit lets the counters run freely. When the reference is lost, the pulse keeps running from the programmed counts, and any pending request waits until the reference is valid again and the anchor line has been seen. A tri-state control can switch off the pulse output, and alignment keeps working while the output is off.

Top module: `tof_align_gen`

## Requirements
- R1: With no reload, `tof` is high for exactly one clock when both counters are at 0. Consecutive pulses are `cfg_ppl * cfg_out_lpf` clocks apart.
- R2: With `cfg_tof_hiz` = 1, `tof_oe` is 0 and `tof` is held at 0, but alignment reloads and `aligned` pulses still occur. With `cfg_tof_hiz` = 0, `tof_oe` is 1.
- R3: H and V coincide when their rising edges are at most `cfg_win` clocks apart (0 to 7). A larger gap gives no anchor line, so no alignment happens.
- R4: Once armed and anchored, the counters reload on the reference line `cfg_offset` lines after the anchor line, modulo `cfg_ref_lpf`. If that line's H rise is first sampled at clock edge k, then `aligned` and `tof` are both high in the cycle after edge k+1.
- R5: With `cfg_offset` = `cfg_ref_lpf`, the reload lands on the anchor line itself.
- R6: An init rising edge while `cfg_offset` is 0 or greater than `cfg_ref_lpf` does not arm the block and sets `cfg_bad` on the next edge. A later valid init edge clears `cfg_bad` and arms the block.
- R7: While `cfg_align_en` stays 1 after arming, a reload and an `aligned` pulse occur on every reference frame. Clearing `cfg_align_en` disarms the block, and the counters run freely.
- R8: An init rising edge is honoured only while `cfg_align_en` is 1. Holding `cfg_init` at 1 while the enable rises does not arm the block.
- R9: While `ref_lost` is 1, no reload occurs, `tof` continues per R1, and an init edge stays pending. After the reference returns, alignment follows the first anchor line seen.
- R10: During reset, both counters are 0, so `tof` is high when enabled, and `aligned` and `cfg_bad` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_h | input | 1 | Reference horizontal sync, synchronous |
| ref_v | input | 1 | Reference vertical sync, synchronous |
| ref_lost | input | 1 | Reference missing |
| cfg_ppl | input | PIX_W | Pixels per output line |
| cfg_out_lpf | input | LINE_W | Output lines per frame |
| cfg_ref_lpf | input | LINE_W | Reference lines per frame |
| cfg_offset | input | LINE_W | Line offset from the anchor line, 1 to cfg_ref_lpf |
| cfg_win | input | WIN_W | Coincidence window in clocks |
| cfg_align_en | input | 1 | Alignment enable |
| cfg_init | input | 1 | Init trigger, rising edge arms |
| cfg_tof_hiz | input | 1 | Turns the TOF driver off |
| tof | output | 1 | Top-of-frame pulse |
| tof_oe | output | 1 | TOF output enable |
| aligned | output | 1 | Pulse on the cycle after a counter reload |
| cfg_bad | output | 1 | Last init edge carried an invalid offset |

## Verification
A reload can fall on any clock of the free-running count, including the cycle where the counters would have wrapped by themselves. Stimulus provokes this by giving the reference a 12-clock line against a 10-pixel output line, and by using random offsets and anchor lines, so reloads land at varying counter phases. Each cycle, the bench checks that `tof` appears exactly one frame period after the previous pulse, with the count restarting at each `aligned` pulse, and that `tof` is high in the same cycle as `aligned`. A second collision, between an init edge and loss of reference, is forced directly and judged by the absence of `aligned` until the anchor line has been seen again.

// File: rtl/tof_align_pkg.sv
package tof_align_pkg;

   typedef enum logic {
      ARM_IDLE = 1'b0,
      ARM_SET  = 1'b1
   } arm_state_e;

   // offset is usable when it lies in 1..lines-per-reference-frame
   function automatic logic offset_usable(input logic [31:0] off,
                                          input logic [31:0] lpf);
      return (off != 32'd0) && (off <= lpf);
   endfunction

endpackage

// File: rtl/tof_ref_decoder.sv
module tof_ref_decoder #(
   parameter int LINE_W = 12,
   parameter int WIN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_h,
   input  logic              ref_v,
   input  logic              ref_lost,
   input  logic [WIN_W-1:0]  win,
   input  logic [LINE_W-1:0] ref_lpf,
   input  logic [LINE_W-1:0] tgt,
   output logic              hit_q,
   output logic              synced_q
);
   localparam int AGE_W = WIN_W + 1;
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   logic [1:0]            sync_in;
   logic [1:0]            rise;
   logic [1:0][AGE_W-1:0] age_now;

   assign sync_in = {ref_v, ref_h};

   // one edge detector and age tracker per sync input
   for (genvar g = 0; g < 2; g++) begin : g_trk
      logic             prev_q;
      logic [AGE_W-1:0] age_q;

      assign rise[g]    = sync_in[g] & ~prev_q;
      assign age_now[g] = rise[g] ? '0 :
                          ((age_q == AGE_MAX) ? AGE_MAX : age_q + 1'b1);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            age_q  <= AGE_MAX;
         end else begin
            prev_q <= sync_in[g];
            age_q  <= age_now[g];
         end
      end
   end

   logic              coin_lvl, coin_q, coin_evt;
   logic [LINE_W-1:0] dist_q, dist_d;
   logic              hit_d, synced_d;

   assign coin_lvl = (age_now[0] <= {1'b0, win}) && (age_now[1] <= {1'b0, win});
   assign coin_evt = coin_lvl & ~coin_q;

   always_comb begin
      dist_d = dist_q;
      if (coin_evt)
         dist_d = '0;
      else if (rise[0])
         dist_d = (dist_q >= ref_lpf - 1'b1) ? '0 : dist_q + 1'b1;
   end

   always_comb begin
      synced_d = synced_q;
      if (ref_lost)
         synced_d = 1'b0;
      else if (coin_evt)
         synced_d = 1'b1;
   end

   assign hit_d = synced_q && !ref_lost && (dist_d != dist_q) && (dist_d == tgt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coin_q   <= 1'b0;
         dist_q   <= '0;
         synced_q <= 1'b0;
         hit_q    <= 1'b0;
      end else begin
         coin_q   <= coin_lvl;
         dist_q   <= dist_d;
         synced_q <= synced_d;
         hit_q    <= hit_d;
      end
   end

   assert_lost_drops_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_lost |=> !synced_q);

   assert_dist_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dist_q < ref_lpf) |=> ((dist_q < ref_lpf) || !$stable(ref_lpf)));

endmodule

// File: rtl/tof_align_ctrl.sv
module tof_align_ctrl
   import tof_align_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic align_en,
   input  logic init,
   input  logic off_ok,
   input  logic ref_lost,
   input  logic hit,
   output logic reload,
   output logic aligned_q,
   output logic bad_q
);
   arm_state_e arm_q, arm_d;
   logic       init_q, init_rise, bad_d;

   assign init_rise = init & ~init_q;

   always_comb begin
      arm_d = arm_q;
      bad_d = bad_q;
      if (!align_en) begin
         arm_d = ARM_IDLE;
      end else if (init_rise) begin
         bad_d = !off_ok;
         if (off_ok)
            arm_d = ARM_SET;
      end
   end

   assign reload = (arm_q == ARM_SET) & align_en & ~ref_lost & hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q     <= ARM_IDLE;
         init_q    <= 1'b0;
         bad_q     <= 1'b0;
         aligned_q <= 1'b0;
      end else begin
         arm_q     <= arm_d;
         init_q    <= init;
         bad_q     <= bad_d;
         aligned_q <= reload;
      end
   end

   assert_bad_init_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (init_rise && align_en && !off_ok) |=> bad_q);

   assert_aligned_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_q |-> ($past(arm_q) == ARM_SET));

   assert_lost_blocks_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_lost |=> !aligned_q);

endmodule

// File: rtl/tof_frame_counter.sv
module tof_frame_counter #(
   parameter int PIX_W  = 12,
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  ppl,
   input  logic [LINE_W-1:0] lpf,
   input  logic              reload,
   output logic              sof
);
   logic [PIX_W-1:0]  pix_q, pix_d;
   logic [LINE_W-1:0] line_q, line_d;

   always_comb begin
      pix_d  = pix_q + 1'b1;
      line_d = line_q;
      if (pix_q >= ppl - 1'b1) begin
         pix_d  = '0;
         line_d = (line_q >= lpf - 1'b1) ? '0 : line_q + 1'b1;
      end
      if (reload) begin
         pix_d  = '0;
         line_d = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_q  <= '0;
         line_q <= '0;
      end else begin
         pix_q  <= pix_d;
         line_q <= line_d;
      end
   end

   assign sof = (pix_q == '0) && (line_q == '0);

   assert_single_tof_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && (ppl > 1) && !reload) |=> !sof);

endmodule

// File: rtl/tof_align_gen.sv
module tof_align_gen
   import tof_align_pkg::*;
#(
   parameter int PIX_W  = 12,
   parameter int LINE_W = 12,
   parameter int WIN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_h,
   input  logic              ref_v,
   input  logic              ref_lost,
   input  logic [PIX_W-1:0]  cfg_ppl,
   input  logic [LINE_W-1:0] cfg_out_lpf,
   input  logic [LINE_W-1:0] cfg_ref_lpf,
   input  logic [LINE_W-1:0] cfg_offset,
   input  logic [WIN_W-1:0]  cfg_win,
   input  logic              cfg_align_en,
   input  logic              cfg_init,
   input  logic              cfg_tof_hiz,
   output logic              tof,
   output logic              tof_oe,
   output logic              aligned,
   output logic              cfg_bad
);
   if (PIX_W < 2 || PIX_W > 16) begin : g_chk_pix
      $error("tof_align_gen: PIX_W out of range");
   end
   if (LINE_W < 2 || LINE_W > 16) begin : g_chk_line
      $error("tof_align_gen: LINE_W out of range");
   end
   if (WIN_W < 1 || WIN_W > 4) begin : g_chk_win
      $error("tof_align_gen: WIN_W out of range");
   end

   logic [LINE_W-1:0] tgt;
   logic              off_ok, hit, synced, reload, sof;

   assign off_ok = offset_usable(32'(cfg_offset), 32'(cfg_ref_lpf));
   assign tgt    = (cfg_offset == cfg_ref_lpf) ? '0 : cfg_offset;

   tof_ref_decoder #(.LINE_W(LINE_W), .WIN_W(WIN_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_h    (ref_h),
      .ref_v    (ref_v),
      .ref_lost (ref_lost),
      .win      (cfg_win),
      .ref_lpf  (cfg_ref_lpf),
      .tgt      (tgt),
      .hit_q    (hit),
      .synced_q (synced)
   );

   tof_align_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .align_en  (cfg_align_en),
      .init      (cfg_init),
      .off_ok    (off_ok),
      .ref_lost  (ref_lost),
      .hit       (hit),
      .reload    (reload),
      .aligned_q (aligned),
      .bad_q     (cfg_bad)
   );

   tof_frame_counter #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ppl    (cfg_ppl),
      .lpf    (cfg_out_lpf),
      .reload (reload),
      .sof    (sof)
   );

   assign tof_oe = ~cfg_tof_hiz;
   assign tof    = sof & tof_oe;

   assert_aligned_at_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
      aligned |-> sof);

   assert_hit_after_anchor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(synced));

endmodule

// File: tb/tof_align_gen_bench.sv
module tof_align_gen_bench;
   localparam int PIX_W = 12, LINE_W = 12, WIN_W = 3;
   localparam int PPL = 10, OLPF = 5, PER = PPL * OLPF;
   localparam int RLPF = 7, RP = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_h = 1'b0, ref_v = 1'b0, ref_lost = 1'b0;
   logic [PIX_W-1:0]  cfg_ppl = PIX_W'(PPL);
   logic [LINE_W-1:0] cfg_out_lpf = LINE_W'(OLPF);
   logic [LINE_W-1:0] cfg_ref_lpf = LINE_W'(RLPF);
   logic [LINE_W-1:0] cfg_offset = LINE_W'(1);
   logic [WIN_W-1:0]  cfg_win = '0;
   logic cfg_align_en = 1'b0, cfg_init = 1'b0, cfg_tof_hiz = 1'b0;
   logic tof, tof_oe, aligned, cfg_bad;

   always #4 clk = ~clk;

   tof_align_gen #(.PIX_W(PIX_W), .LINE_W(LINE_W), .WIN_W(WIN_W)) u_tof_align_gen (
      .clk(clk), .rst_n(rst_n), .ref_h(ref_h), .ref_v(ref_v), .ref_lost(ref_lost),
      .cfg_ppl(cfg_ppl), .cfg_out_lpf(cfg_out_lpf), .cfg_ref_lpf(cfg_ref_lpf),
      .cfg_offset(cfg_offset), .cfg_win(cfg_win), .cfg_align_en(cfg_align_en),
      .cfg_init(cfg_init), .cfg_tof_hiz(cfg_tof_hiz),
      .tof(tof), .tof_oe(tof_oe), .aligned(aligned), .cfg_bad(cfg_bad));

   int  n_chk = 0, n_bad = 0;
   bit  done = 0;
   // bench model state
   bit  b_armed = 0, b_synced = 0, b_bad = 0;
   int  vl = 3, vd = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int tgt_line(input int off);
      return ((vl - 1 + off) % RLPF) + 1;
   endfunction

   // R1: tof period monitor, restarted by each alignment
   int cyc = 0, last_tof = 0;
   bit have_last = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         if (!tof_oe) begin
            have_last = 0;
         end else if (aligned) begin
            last_tof  = cyc;
            have_last = 1;
         end else if (have_last) begin
            chk(tof == ((cyc - last_tof) == PER), "R1", "tof period",
                int'(tof), int'((cyc - last_tof) == PER));
            if (tof) last_tof = cyc;
         end else if (tof) begin
            last_tof  = cyc;
            have_last = 1;
         end
      end
   end

   task automatic send_line(input int ln, input string tag);
      bit cur_v = (ln == vl);
      bit exp = b_armed && cfg_align_en && !ref_lost && b_synced &&
                (ln == tgt_line(int'(cfg_offset)));
      for (int i = 0; i < RP; i++) begin
         @(negedge clk);
         chk(aligned == (exp && i == 2), tag, "aligned", int'(aligned), int'(exp && i == 2));
         if (exp && i == 2)
            chk(tof == !cfg_tof_hiz, tag, "tof with aligned", int'(tof), int'(!cfg_tof_hiz));
         ref_h = (i == 0);
         ref_v = cur_v && (i == vd);
      end
      if (ref_lost) b_synced = 0;
      else if (cur_v && vd <= int'(cfg_win)) b_synced = 1;
   endtask

   task automatic send_frame(input string tag);
      for (int ln = 1; ln <= RLPF; ln++) send_line(ln, tag);
   endtask

   task automatic set_en(input bit v);
      @(negedge clk);
      cfg_align_en = v;
      if (!v) b_armed = 0;
   endtask

   task automatic pulse_init(input string tag);
      bit ok = (cfg_offset != 0) && (cfg_offset <= cfg_ref_lpf);
      @(negedge clk);
      cfg_init = 1'b1;
      if (cfg_align_en) begin
         b_bad = !ok;
         if (ok) b_armed = 1;
      end
      @(negedge clk);
      chk(cfg_bad == b_bad, tag, "cfg_bad", int'(cfg_bad), int'(b_bad));
      cfg_init = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5eed));
      repeat (4) @(negedge clk);
      // R10: reset state
      chk(tof == 1'b1, "R10", "tof in reset", int'(tof), 1);
      chk(aligned == 1'b0, "R10", "aligned in reset", int'(aligned), 0);
      chk(cfg_bad == 1'b0, "R10", "cfg_bad in reset", int'(cfg_bad), 0);
      chk(tof_oe == 1'b1, "R2", "tof_oe enabled", int'(tof_oe), 1);
      rst_n = 1'b1;

      // R3: V three clocks after H, window 2 -> no anchor
      vl = 3; vd = 3; cfg_win = 3'd2; cfg_offset = 2;
      set_en(1); pulse_init("R3");
      send_frame("R3"); send_frame("R3");
      cfg_win = 3'd3;
      send_frame("R3"); send_frame("R4");

      // R7: disabling stops alignment
      set_en(0);
      send_frame("R7");

      // R5: offset equal to reference frame length
      vd = 0; cfg_win = 3'd0; cfg_offset = RLPF;
      send_frame("R5");
      set_en(1); pulse_init("R5");
      send_frame("R5"); send_frame("R7");

      // R6: invalid offsets
      set_en(0); set_en(1);
      cfg_offset = 0; pulse_init("R6");
      send_frame("R6");
      cfg_offset = RLPF + 1; pulse_init("R6");
      send_frame("R6");
      cfg_offset = 4; pulse_init("R6");
      chk(cfg_bad == 1'b0, "R6", "cfg_bad cleared", int'(cfg_bad), 0);
      send_frame("R6");

      // R8: init rise while disabled, level held while enable rises
      set_en(0);
      @(negedge clk); cfg_init = 1'b1;
      repeat (3) @(negedge clk);
      set_en(1);
      send_frame("R8");
      @(negedge clk); cfg_init = 1'b0;

      // R9: loss of reference with a pending request
      set_en(0); set_en(1);
      @(negedge clk); ref_lost = 1'b1; b_synced = 0;
      pulse_init("R9");
      send_frame("R9"); send_frame("R9");
      @(negedge clk); ref_lost = 1'b0;
      send_frame("R9"); send_frame("R9");

      // R2: driver off, alignment continues
      @(negedge clk); cfg_tof_hiz = 1'b1;
      @(negedge clk);
      chk(tof_oe == 1'b0, "R2", "tof_oe off", int'(tof_oe), 0);
      send_frame("R2");
      chk(tof == 1'b0, "R2", "tof held low", int'(tof), 0);
      @(negedge clk); cfg_tof_hiz = 1'b0;

      // random rounds
      for (int r = 0; r < 6; r++) begin
         int w;
         set_en(0);
         w          = int'($urandom % 8);
         cfg_win    = WIN_W'(w);
         vd         = int'($urandom % (w + 1));
         vl         = int'($urandom % RLPF) + 1;
         cfg_offset = LINE_W'(int'($urandom % RLPF) + 1);
         send_frame("R4");
         set_en(1); pulse_init("R4");
         send_frame("R4"); send_frame("R7"); send_frame("R7");
         set_en(0);
         send_frame("R7");
      end

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule